// File: doc/BRIEF.md
# Serial Signature Analyzer

This block compacts a serial test response into a short signature. Every response bit marked valid is fed into an N-stage linear feedback shift register that starts at all-zero. When the test ends, the register contents are compared with a fault-free signature given as a parameter, and a pass or fail verdict is produced. The block is meant to sit at the output of a circuit under test during built-in self-test, next to a pattern generator and a test sequencer.

Two register structures can be chosen by parameter. The internal-XOR form divides the response polynomial by the characteristic polynomial, so its final contents are the remainder. The first bit received is the highest-degree coefficient. The external-XOR form runs the same polynomial as a feedback recurrence whose newest value enters stage 0. A clear input starts a new run. After the end strobe the signature and verdict stay frozen until the next clear. A faulty stream is missed only when its signature aliases the fault-free one. For long streams with every error pattern equally likely, this happens for about one stream in 2^N.

Top module: `sig_analyzer`

## Requirements
- R1: After the asynchronous reset, or one cycle after `clear_i` is sampled high, `sig_o` is all-zero and `done_o` and `pass_o` are low. `clear_i` takes priority over every other input.
- R2: In internal-XOR form (`FORM` = `SA_INTERNAL`), `sig_o` bit i holds the coefficient of X^i in the remainder of M(X) divided by P(X). M(X) is built from the accepted bits with the first bit as the highest degree. P(X) is X^WIDTH plus the terms set in `POLY`, where `POLY` bit i is the coefficient of X^i. The new value appears one cycle after each accepted bit.
- R3: With WIDTH=3 and `POLY`=3'b011, so that P(X)=1+X+X^3, the stream 1,0,1,1,0,0,0,1 leaves `sig_o`=3'b001, which reads 1,0,0 in stage order.
- R4: In external-XOR form (`FORM` = `SA_EXTERNAL`), each accepted bit shifts the register one place from stage 0 toward stage WIDTH-1. Stage 0 loads the input bit XOR stage WIDTH-1 XOR every stage j below WIDTH-1 for which `POLY` bit j+1 is set. `POLY` bit 0 is unused in this form.
- R5: A cycle with `bit_valid_i` low leaves `sig_o` unchanged.
- R6: One cycle after `end_i` is sampled high while `done_o` is low, `done_o` is high. In that same cycle `pass_o` is high exactly when the signature equals `GOLDEN`. A stream that differs from the fault-free stream gives `pass_o` low unless its signature aliases.
- R7: While `done_o` is high and no clear arrives, `sig_o`, `done_o` and `pass_o` hold their values. Further valid bits and end strobes are ignored.
- R8: A valid bit presented in the same cycle as `end_i` is part of the signature used for the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart to the all-zero state |
| bit_valid_i | input | 1 | Qualifies `bit_i` in this cycle |
| bit_i | input | 1 | Serial response bit |
| end_i | input | 1 | End-of-test strobe |
| sig_o | output | WIDTH | Current signature |
| done_o | output | 1 | Verdict valid |
| pass_o | output | 1 | Signature matched `GOLDEN` |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it. The signature moves on the edge that samples a valid bit, and `done_o` and `pass_o` rise on the edge that samples the end strobe. The bench drives each input at a falling edge and updates its behavioural model from those same inputs. After the next rising edge it waits for the falling edge, then compares all outputs of three instances: a 16-bit internal form, the 3-bit worked example and a 16-bit external form. The internal model does long division over the stored bit queue. The external model runs the recurrence over a history queue.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic {SA_INTERNAL = 1'b0, SA_EXTERNAL = 1'b1} sa_form_e;
endpackage

// File: rtl/sa_div_step.sv
// One division step: shift in the new low-order coefficient, reduce by P(X).
module sa_div_step #(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] POLY = '0
) (
  input  logic [WIDTH-1:0] sig_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] sig_o
);
  logic [WIDTH-1:0] shifted;
  always_comb begin
    shifted = {sig_i[WIDTH-2:0], bit_i};
    sig_o   = sig_i[WIDTH-1] ? (shifted ^ POLY) : shifted;
  end
endmodule

// File: rtl/sa_fib_step.sv
// One recurrence step: stage 0 takes input XOR tapped stages.
module sa_fib_step #(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] POLY = '0
) (
  input  logic [WIDTH-1:0] sig_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] sig_o
);
  logic [WIDTH-1:0] tap_mask;
  for (genvar j = 0; j < WIDTH; j++) begin : g_mask
    if (j == WIDTH-1) begin : g_top
      assign tap_mask[j] = 1'b1;
    end else begin : g_mid
      assign tap_mask[j] = POLY[j+1];
    end
  end
  assign sig_o = {sig_i[WIDTH-2:0], bit_i ^ (^(sig_i & tap_mask))};
endmodule

// File: rtl/sa_verdict.sv
module sa_verdict #(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] GOLDEN = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             end_i,
  input  logic [WIDTH-1:0] sig_nxt_i,
  output logic             done_o,
  output logic             pass_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else if (clear_i) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else if (end_i && !done_o) begin
      done_o <= 1'b1;
      pass_o <= (sig_nxt_i == GOLDEN);
    end
  end
endmodule

// File: rtl/sig_analyzer.sv
module sig_analyzer
  import sa_pkg::*;
#(
  parameter int unsigned      WIDTH  = 16,
  parameter logic [WIDTH-1:0] POLY   = 16'h8005,
  parameter logic [WIDTH-1:0] GOLDEN = '0,
  parameter sa_form_e         FORM   = SA_INTERNAL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  input  logic             end_i,
  output logic [WIDTH-1:0] sig_o,
  output logic             done_o,
  output logic             pass_o
);
  logic [WIDTH-1:0] sig_q, step_sig, sig_nxt;
  logic             accept;

  if (FORM == SA_INTERNAL) begin : g_div
    sa_div_step #(.WIDTH(WIDTH), .POLY(POLY)) u_step (
      .sig_i(sig_q), .bit_i(bit_i), .sig_o(step_sig));
  end else begin : g_fib
    sa_fib_step #(.WIDTH(WIDTH), .POLY(POLY)) u_step (
      .sig_i(sig_q), .bit_i(bit_i), .sig_o(step_sig));
  end

  assign accept  = bit_valid_i && !done_o;
  assign sig_nxt = accept ? step_sig : sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sig_q <= '0;
    else if (clear_i) sig_q <= '0;
    else              sig_q <= sig_nxt;
  end

  sa_verdict #(.WIDTH(WIDTH), .GOLDEN(GOLDEN)) u_verdict (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .end_i(end_i),
    .sig_nxt_i(sig_nxt), .done_o(done_o), .pass_o(pass_o));

  assign sig_o = sig_q;
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
  parameter int unsigned      WIDTH  = 16,
  parameter logic [WIDTH-1:0] GOLDEN = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             bit_valid_i,
  input logic             end_i,
  input logic [WIDTH-1:0] sig_o,
  input logic             done_o,
  input logic             pass_o
);
  a_r1_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sig_o == '0 && !done_o && !pass_o));
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_valid_i && !clear_i) |=> $stable(sig_o));
  a_r6_done_follows_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && !clear_i) |=> done_o);
  a_r6_no_early_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !end_i) |=> !done_o);
  a_r6_pass_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (done_o && sig_o == GOLDEN));
  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |=> (done_o && $stable(sig_o) && $stable(pass_o)));
endmodule

bind sig_analyzer sa_checker #(.WIDTH(WIDTH), .GOLDEN(GOLDEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .bit_valid_i(bit_valid_i),
  .end_i(end_i), .sig_o(sig_o), .done_o(done_o), .pass_o(pass_o));

// File: tb/sim_sig_analyzer.sv
module sim_sig_analyzer;
  import sa_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clear = 1'b0, valid = 1'b0, bit_in = 1'b0, fin = 1'b0;
  logic [15:0] sig0, sig2;
  logic [2:0]  sig1;
  logic [2:0]  done_v, pass_v;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_analyzer #(.WIDTH(16), .POLY(16'h8005), .GOLDEN(16'h0000), .FORM(SA_INTERNAL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .bit_valid_i(valid), .bit_i(bit_in),
    .end_i(fin), .sig_o(sig0), .done_o(done_v[0]), .pass_o(pass_v[0]));
  sig_analyzer #(.WIDTH(3), .POLY(3'b011), .GOLDEN(3'b001), .FORM(SA_INTERNAL)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .bit_valid_i(valid), .bit_i(bit_in),
    .end_i(fin), .sig_o(sig1), .done_o(done_v[1]), .pass_o(pass_v[1]));
  sig_analyzer #(.WIDTH(16), .POLY(16'h002D), .GOLDEN(16'h0000), .FORM(SA_EXTERNAL)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .bit_valid_i(valid), .bit_i(bit_in),
    .end_i(fin), .sig_o(sig2), .done_o(done_v[2]), .pass_o(pass_v[2]));

  // behavioural model state
  bit q_bits[$];
  bit hist[$];
  bit done_m = 1'b0;
  logic [15:0] gold_m [3] = '{16'h0000, 16'h0001, 16'h0000};
  bit pass_m [3] = '{1'b0, 1'b0, 1'b0};

  function automatic logic [15:0] remainder(int w, logic [15:0] poly);
    logic [16:0] r = '0;
    foreach (q_bits[i]) begin
      r = {r[15:0], q_bits[i]};
      if (r[w]) r = r ^ ((17'(1) << w) | {1'b0, poly});
    end
    return r[15:0];
  endfunction

  function automatic logic [15:0] ext_sig();
    logic [15:0] s = '0;
    for (int j = 0; j < 16; j++)
      if (hist.size() > j) s[j] = hist[hist.size()-1-j];
    return s;
  endfunction

  function automatic logic [15:0] model_sig(int k);
    case (k)
      0: return remainder(16, 16'h8005);
      1: return remainder(3, 16'h0003);
      default: return ext_sig();
    endcase
  endfunction

  function automatic void ext_push(bit b);
    bit fb = b;
    int n = hist.size();
    for (int i = 1; i <= 16; i++) begin
      bit c = (i == 16) ? 1'b1 : ((16'h002D >> i) & 1'b1);
      if (c && n >= i) fb ^= hist[n-i];
    end
    hist.push_back(fb);
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] dut_sig(int k);
    case (k)
      0: return sig0;
      1: return {13'b0, sig1};
      default: return sig2;
    endcase
  endfunction

  task automatic compare_all();
    for (int k = 0; k < 3; k++) begin
      logic [15:0] e = model_sig(k);
      check(dut_sig(k) == e, (k == 2) ? "R4 sig" : "R2 sig", dut_sig(k), e);
      check(done_v[k] == done_m, "R6 done", 16'(done_v[k]), 16'(done_m));
      check(pass_v[k] == pass_m[k], "R6 pass", 16'(pass_v[k]), 16'(pass_m[k]));
    end
  endtask

  task automatic step(bit v, bit b, bit e, bit c);
    valid = v; bit_in = b; fin = e; clear = c;
    if (c) begin
      q_bits.delete(); hist.delete(); done_m = 1'b0;
      for (int k = 0; k < 3; k++) pass_m[k] = 1'b0;
    end else begin
      if (v && !done_m) begin q_bits.push_back(b); ext_push(b); end
      if (e && !done_m) begin
        done_m = 1'b1;
        for (int k = 0; k < 3; k++) pass_m[k] = (model_sig(k) == gold_m[k]);
      end
    end
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0; bit_in = 1'b0; fin = 1'b0; clear = 1'b0;
    compare_all();
  endtask

  task automatic feed(logic [7:0] pat);
    for (int i = 7; i >= 0; i--) begin
      step(1'b1, pat[i], 1'b0, 1'b0);
      if (i == 4) step(1'b0, 1'b1, 1'b0, 1'b0); // gap with junk bit
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sig0 == 0 && sig1 == 0 && sig2 == 0 && done_v == 0 && pass_v == 0,
          "R1 reset", {sig0[7:0], 2'b0, done_v, pass_v}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: worked example 10110001 with gaps (R5)
    feed(8'b1011_0001);
    check(sig1 == 3'b001, "R3 example", {13'b0, sig1}, 16'h0001);
    held = sig0;
    step(1'b0, 1'b1, 1'b0, 1'b0);
    check(sig0 == held, "R5 idle", sig0, held);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check(done_v[1] && pass_v[1], "R6 golden pass", {14'b0, done_v[1], pass_v[1]}, 16'h3);

    // R7: frozen after done
    held = sig0;
    step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    check(sig0 == held && done_v[0], "R7 frozen", sig0, held);
    check(pass_v[1], "R7 pass held", 16'(pass_v[1]), 16'h1);

    // R1: clear, then flipped stream fails
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check(sig0 == 0 && sig1 == 0 && done_v == 0 && pass_v == 0, "R1 clear",
          {sig0[7:0], 2'b0, done_v, pass_v}, 16'h0);
    feed(8'b1011_0011);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check(done_v[1] && !pass_v[1], "R6 fault caught", {14'b0, done_v[1], pass_v[1]}, 16'h2);

    // all-zero stream passes the zero golden
    step(1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check(pass_v[0] && pass_v[2], "R6 zero pass", {14'b0, pass_v[0], pass_v[2]}, 16'h3);

    // clear mid-stream, long random stream, end with last bit (R8)
    step(1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, 1'($urandom_range(0, 1)), 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 300; i++)
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    check(sig0 == remainder(16, 16'h8005) && q_bits[q_bits.size()-1] == 1'b1,
          "R8 last bit in", sig0, remainder(16, 16'h8005));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule